// File: doc/BRIEF.md
# Pixel Clock Divider with Bypass

This block turns a fast reference clock into the pacing signals for a display pipeline. It produces three outputs. The first is a one-cycle pixel strobe that advances the timing generator. The second is a divided panel clock level for the output pad. The third is a flag that tells the data launch logic which panel clock edge moves the pixel data. All three come from one 32-bit control word, which is normally the timing/polarity register seen by software.

The divide ratio is built from two separate fields of that word. A five-bit field near the bottom of the word gives the lower bits, and a five-bit field at the top of the word gives the upper bits. The joined ten-bit value plus two is the ratio, so the ratio ranges from 2 to 1025. A bypass bit overrides the fields and runs the pixel strobe at the full reference rate. An inversion bit moves data launch to the falling panel clock edge.

Settings are captured only when a period begins, so a write in the middle of a period cannot shorten the clock pulse in progress. An enable input starts and stops the divider.

Top module: `pixclk_divider`

## Requirements
- R1: While reset is asserted, and on every cycle after a clock edge at which `en_i` was low, `pix_en_o`, `panel_clk_o` and `launch_fall_o` are all 0.
- R2: With bypass clear, the ratio N is {cfg_i[31:27], cfg_i[4:0]} + 2, with cfg_i[31:27] as the upper five bits. `pix_en_o` is high for exactly one cycle in every N cycles.
- R3: With bypass clear, `panel_clk_o` is high for floor(N/2) cycles, starting in the same cycle as the `pix_en_o` pulse. It is low for the remaining N − floor(N/2) cycles of the period.
- R4: Both fields at all ones (joined value 1023) give a period of 1025 cycles.
- R5: When cfg_i[26] (bypass) is 1, `pix_en_o` and `panel_clk_o` are both high on every enabled cycle, and the two divisor fields have no effect.
- R6: `launch_fall_o` copies cfg_i[13] while the divider runs. A 1 selects data launch on the falling panel clock edge and a 0 selects the rising edge.
- R7: A change to `cfg_i` takes effect only at the start of the next period. The period in progress keeps its ratio, bypass and edge setting.
- R8: The first period starts at the clock edge where `en_i` is first seen high: `pix_en_o` and `panel_clk_o` are high in the cycle after that edge.
- R9: Bits of `cfg_i` outside [31:26], [13] and [4:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Divider run enable |
| cfg_i | input | 32 | Control word: divisor fields, bypass and edge select |
| pix_en_o | output | 1 | One-cycle pixel strobe per period |
| panel_clk_o | output | 1 | Divided panel clock level |
| launch_fall_o | output | 1 | 1 = data launches on the falling panel clock edge |

## Verification
Two events can land in the same cycle. A configuration write can arrive in the last cycle of a period, and it then meets the boundary where settings are captured. An enable change can also arrive exactly as a period wraps. The bench makes these collisions happen by rewriting `cfg_i` and toggling `en_i` at random phases, including the final cycle of short periods. Every cycle it compares all three outputs against a model that applies new settings only at the period boundary.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  parameter int unsigned LO_W    = 5;
  parameter int unsigned HI_W    = 5;
  parameter int unsigned WORD_W  = 32;
  localparam int unsigned JOIN_W  = LO_W + HI_W;
  localparam int unsigned RATIO_W = JOIN_W + 1;

  typedef struct packed {
    logic               byp;
    logic               inv;
    logic [RATIO_W-1:0] ratio;
  } pcd_cfg_t;
endpackage

// File: rtl/pcd_ratio_decode.sv
module pcd_ratio_decode
  import pcd_pkg::*;
#(
  parameter int unsigned LO_LSB  = 0,
  parameter int unsigned HI_LSB  = 27,
  parameter int unsigned BYP_BIT = 26,
  parameter int unsigned INV_BIT = 13
) (
  input  logic [WORD_W-1:0] word_i,
  output pcd_cfg_t          cfg_o
);
  logic [JOIN_W-1:0] joined;

  always_comb begin
    joined       = {word_i[HI_LSB +: HI_W], word_i[LO_LSB +: LO_W]};
    cfg_o.byp    = word_i[BYP_BIT];
    cfg_o.inv    = word_i[INV_BIT];
    cfg_o.ratio  = RATIO_W'(joined) + RATIO_W'(2);
  end
endmodule

// File: rtl/pcd_phase_counter.sv
module pcd_phase_counter
  import pcd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  pcd_cfg_t           cfg_i,
  output logic               nxt_run_o,
  output logic [RATIO_W-1:0] nxt_cnt_o,
  output pcd_cfg_t           nxt_cfg_o
);
  logic               run_q;
  logic [RATIO_W-1:0] cnt_q;
  pcd_cfg_t           cur_q;
  logic               last;

  assign last = cur_q.byp || (cnt_q == cur_q.ratio - RATIO_W'(1));

  always_comb begin
    nxt_run_o = 1'b1;
    nxt_cnt_o = cnt_q + RATIO_W'(1);
    nxt_cfg_o = cur_q;
    if (!en_i) begin
      nxt_run_o = 1'b0;
      nxt_cnt_o = '0;
    end else if (!run_q || last) begin
      nxt_cnt_o = '0;
      nxt_cfg_o = cfg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      cur_q <= '0;
    end else begin
      run_q <= nxt_run_o;
      cnt_q <= nxt_cnt_o;
      cur_q <= nxt_cfg_o;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !cur_q.byp) |-> (cnt_q < cur_q.ratio)); // R2

  AST_CFG_HELD_MID_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !last && en_i) |=> $stable(cur_q)); // R7

  AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!run_q && cnt_q == '0)); // R8
endmodule

// File: rtl/pcd_out_stage.sv
module pcd_out_stage
  import pcd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               nxt_run_i,
  input  logic [RATIO_W-1:0] nxt_cnt_i,
  input  pcd_cfg_t           nxt_cfg_i,
  output logic               pix_en_o,
  output logic               panel_clk_o,
  output logic               launch_fall_o
);
  logic [RATIO_W-1:0] half;
  logic pix_d, pclk_d, lf_d;

  always_comb begin
    half   = nxt_cfg_i.ratio >> 1;
    pix_d  = nxt_run_i && (nxt_cfg_i.byp || nxt_cnt_i == '0);
    pclk_d = nxt_run_i && (nxt_cfg_i.byp || nxt_cnt_i < half);
    lf_d   = nxt_run_i && nxt_cfg_i.inv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_en_o      <= 1'b0;
      panel_clk_o   <= 1'b0;
      launch_fall_o <= 1'b0;
    end else begin
      pix_en_o      <= pix_d;
      panel_clk_o   <= pclk_d;
      launch_fall_o <= lf_d;
    end
  end

  AST_RISE_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(panel_clk_o) |-> pix_en_o); // R3
endmodule

// File: rtl/pixclk_divider.sv
module pixclk_divider
  import pcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [31:0]       cfg_i,
  output logic              pix_en_o,
  output logic              panel_clk_o,
  output logic              launch_fall_o
);
  pcd_cfg_t           dec_cfg;
  pcd_cfg_t           nxt_cfg;
  logic               nxt_run;
  logic [RATIO_W-1:0] nxt_cnt;

  pcd_ratio_decode u_decode (
    .word_i (cfg_i),
    .cfg_o  (dec_cfg)
  );

  pcd_phase_counter u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .cfg_i     (dec_cfg),
    .nxt_run_o (nxt_run),
    .nxt_cnt_o (nxt_cnt),
    .nxt_cfg_o (nxt_cfg)
  );

  pcd_out_stage u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .nxt_run_i     (nxt_run),
    .nxt_cnt_i     (nxt_cnt),
    .nxt_cfg_i     (nxt_cfg),
    .pix_en_o      (pix_en_o),
    .panel_clk_o   (panel_clk_o),
    .launch_fall_o (launch_fall_o)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pix_en_o && !panel_clk_o && !launch_fall_o)); // R1
endmodule

// File: tb/pixclk_divider_bench.sv
module pixclk_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] cfg = '0;
  logic        pix, pclk, lf;
  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  bit          m_run = 1'b0;
  int unsigned m_p = 0, m_n = 2;
  bit          m_byp = 1'b0, m_inv = 1'b0;

  always #2.5 clk = ~clk;

  pixclk_divider u_pixclk_divider (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_i(cfg),
    .pix_en_o(pix), .panel_clk_o(pclk), .launch_fall_o(lf)
  );

  function automatic int unsigned ratio_of(logic [31:0] w);
    return int'({w[31:27], w[4:0]}) + 2;
  endfunction

  task automatic model_edge();
    if (!en) begin
      m_run = 1'b0; m_p = 0;
    end else if (!m_run || m_byp || m_p == m_n - 1) begin
      m_run = 1'b1; m_p = 0;
      m_n = ratio_of(cfg); m_byp = cfg[26]; m_inv = cfg[13];
    end else begin
      m_p++;
    end
  endtask

  task automatic check(string req);
    bit e_pix, e_clk, e_lf;
    e_pix = m_run && (m_byp || m_p == 0);
    e_clk = m_run && (m_byp || m_p < m_n / 2);
    e_lf  = m_run && m_inv;
    n_checks++;
    if (pix !== e_pix || pclk !== e_clk || lf !== e_lf) begin
      n_fail++;
      $display("FAIL %s: pix/clk/lf actual %b%b%b expected %b%b%b (phase %0d of %0d)",
               req, pix, pclk, lf, e_pix, e_clk, e_lf, m_p, m_n);
    end
  endtask

  task automatic step(string req);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic run_cycles(int unsigned n, string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    run_cycles(3, "R1");

    // R8 and R2/R3: ratio 2, then odd ratio 3
    cfg = 32'h0; en = 1'b1;
    run_cycles(8, "R8");
    cfg = 32'h1;
    run_cycles(12, "R3");
    // R2 with upper field: {00001,00101}=37 -> 39
    cfg = (32'h1 << 27) | 32'h5;
    run_cycles(90, "R2");
    // R4 max divisor
    cfg = 32'hF800_001F;
    run_cycles(2100, "R4");
    // R5 bypass with garbage divisor fields
    cfg = 32'hF800_001F | (32'h1 << 26);
    run_cycles(20, "R5");
    // R6 inversion
    cfg = 32'h2 | (32'h1 << 13);
    run_cycles(20, "R6");
    // R9 unrelated bits toggled
    cfg = 32'h03FF_DFE3;
    run_cycles(20, "R9");
    // R1 disable
    en = 1'b0;
    run_cycles(5, "R1");
    en = 1'b1;

    // R7 random config changes and enable toggles at any phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        w = $urandom;
        if ($urandom_range(0, 7) != 0) w[31:27] = 5'd0;
        w[26] = ($urandom_range(0, 7) == 0);
        cfg = w;
      end
      if ($urandom_range(0, 59) == 0) en = ~en;
      step("R7");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule